// File: doc/BRIEF.md
# Inbound Request Ordering Stall Unit

This block stands in front of a memory-access engine. It holds back an inbound read or write request while an earlier request of the same kind of flow is still in flight. Each request it accepts goes straight out on the DMA issue interface in the same cycle, together with a tag. The tag names a slot in an internal pending table. The slot stays occupied until the DMA side returns a completion carrying that tag.

A new request is held while any pending slot has the same source ID, the same destination ID and a priority at least as high as the new one. Posted writes are tracked and compared in the same way as requests that expect a response. A full table also holds the incoming request. Requests are taken strictly in arrival order on a single valid/ready input, so a stalled request blocks every request behind it.

When a request that needs a response completes, the block emits a response header. The header goes back to the port the request arrived on, and its source and destination IDs are the request's IDs swapped.

Top module: `ios_order_stall`

## Requirements
- R1: After synchronous active-low reset the table is empty. `req_ready` is 1 and `rsp_valid` is 0 until a completion is seen.
- R2: An accepted request (`req_valid` and `req_ready` both 1) appears in the same cycle on `iss_valid`, with `iss_src`, `iss_dst`, `iss_prio` and `iss_kind` equal to the request fields. `iss_valid` is 0 in every other cycle.
- R3: `req_ready` is 0 while a pending entry has an equal source ID, an equal destination ID and a priority greater than or equal to `req_prio`. Priority is an unsigned 2-bit value and 3 is the highest.
- R4: A pending entry with a lower priority, a different source ID or a different destination ID does not stall the request, and the request passes with no added cycle.
- R5: The stall lasts until every matching entry has completed. A completion for an entry frees it in the same cycle, so a request presented in the cycle of the last matching completion is accepted in that cycle.
- R6: Posted requests are tracked and stall later requests exactly like non-posted ones. The kind encoding is 0 = read and 1 = write needing a response (both non-posted), 2 = posted write and 3 = posted stream write.
- R7: With all 8 entries pending, `req_ready` is 0. A completion for a pending tag in the same cycle makes room, and the request is accepted in that cycle if it is otherwise clear.
- R8: `iss_tag` is the lowest table index that is free in that cycle, counting an entry freed by a same-cycle completion as free.
- R9: A completion for a pending non-posted entry sets `rsp_valid` in the following cycle. In that cycle `rsp_port` is the request's port, `rsp_src` is the request's destination ID, `rsp_dst` is the request's source ID and `rsp_prio` is the request's priority. A completion for a posted entry gives no response.
- R10: A completion whose tag names no pending entry is ignored. It produces no response and frees nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Inbound request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_src | input | ID_W | Request source ID |
| req_dst | input | ID_W | Request destination ID |
| req_prio | input | PRIO_W | Request priority, 3 highest |
| req_port | input | PORT_W | Ingress port of the request |
| req_kind | input | 2 | Request kind (0 read, 1 write with response, 2 posted write, 3 posted stream write) |
| iss_valid | output | 1 | Request issued to DMA this cycle |
| iss_tag | output | TAG_W | Table slot assigned to the issued request |
| iss_src | output | ID_W | Issued source ID |
| iss_dst | output | ID_W | Issued destination ID |
| iss_prio | output | PRIO_W | Issued priority |
| iss_kind | output | 2 | Issued kind |
| cpl_valid | input | 1 | DMA completion present |
| cpl_tag | input | TAG_W | Tag of the completed request |
| rsp_valid | output | 1 | Response header valid |
| rsp_port | output | PORT_W | Port to send the response on |
| rsp_src | output | ID_W | Response source ID (request destination) |
| rsp_dst | output | ID_W | Response destination ID (request source) |
| rsp_prio | output | PRIO_W | Response priority |

## Verification
The bench targets the priority boundary: an equal priority must stall and a lower pending priority must not. A comparator that is off by one in either direction would pass an equal-priority request or block a lower one. It aims completions and requests at the same cycle, both for the last matching entry and for a full table. A design that frees entries one cycle late would stall for an extra cycle and hand out a higher tag than the lowest free one. It also sends stray completion tags and completions for posted entries; a design that does not check the slot state would emit phantom responses or corrupt the table. Response checks compare the swapped IDs and the stored port, which catches a design that keeps the IDs unswapped or steers the response to the wrong port.

// File: rtl/ios_pkg.sv
// Package: shared encodings for the inbound ordering stall unit.
// Assumes the request kind is a 2-bit code; bit 1 set means posted.
package ios_pkg;

    typedef enum logic [1:0] {
        KIND_READ         = 2'd0,
        KIND_WRITE_ACK    = 2'd1,
        KIND_WRITE_POSTED = 2'd2,
        KIND_STREAM_WRITE = 2'd3
    } req_kind_e;

    // True when the request kind expects a response.
    function automatic logic needs_response(input logic [1:0] kind);
        return (kind == KIND_READ) || (kind == KIND_WRITE_ACK);
    endfunction

endpackage

// File: rtl/ios_entry_match.sv
// Module: compares one pending table entry against the incoming request.
// Flags a hit when the entry is live and has the same source and destination
// IDs and a priority at least as high. Assumes unsigned priority, larger = higher.
module ios_entry_match #(
    parameter int ID_W   = 8,
    parameter int PRIO_W = 2
) (
    input  logic              live,
    input  logic [ID_W-1:0]   ent_src,
    input  logic [ID_W-1:0]   ent_dst,
    input  logic [PRIO_W-1:0] ent_prio,
    input  logic [ID_W-1:0]   new_src,
    input  logic [ID_W-1:0]   new_dst,
    input  logic [PRIO_W-1:0] new_prio,
    output logic              hit
);

    // Ordering conflict: same flow and no lower priority than the newcomer.
    always_comb begin
        hit = live && (ent_src == new_src) && (ent_dst == new_dst)
                   && (ent_prio >= new_prio);
    end

endmodule

// File: rtl/ios_free_pick.sv
// Module: picks the lowest free slot of the pending table.
// Assumes free_vec marks usable slots (including any released this cycle).
module ios_free_pick #(
    parameter int DEPTH = 8,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] free_vec,
    output logic [TAG_W-1:0] pick,
    output logic             any_free
);

    // Scan from the top so the lowest free index is the last one written.
    always_comb begin
        pick     = '0;
        any_free = |free_vec;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_vec[i]) pick = TAG_W'(i);
        end
    end

endmodule

// File: rtl/ios_pend_table.sv
// Module: storage for pending requests, one slot per DMA tag.
// Assumes a write and a release never name the same slot in one cycle
// unless the slot is being reused after its release (write then wins).
module ios_pend_table #(
    parameter int DEPTH  = 8,
    parameter int ID_W   = 8,
    parameter int PRIO_W = 2,
    parameter int PORT_W = 2,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [TAG_W-1:0]              wr_idx,
    input  logic [ID_W-1:0]               wr_src,
    input  logic [ID_W-1:0]               wr_dst,
    input  logic [PRIO_W-1:0]             wr_prio,
    input  logic [PORT_W-1:0]             wr_port,
    input  logic                          wr_np,
    input  logic [DEPTH-1:0]              rel_vec,
    output logic [DEPTH-1:0]              valid_q,
    output logic [DEPTH-1:0][ID_W-1:0]    src_q,
    output logic [DEPTH-1:0][ID_W-1:0]    dst_q,
    output logic [DEPTH-1:0][PRIO_W-1:0]  prio_q,
    output logic [DEPTH-1:0][PORT_W-1:0]  port_q,
    output logic [DEPTH-1:0]              np_q
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic load;
        assign load = wr_en && (wr_idx == TAG_W'(g));

        // Slot occupancy: set on allocation, cleared on release.
        always_ff @(posedge clk) begin
            if (!rst_n)          valid_q[g] <= 1'b0;
            else if (load)       valid_q[g] <= 1'b1;
            else if (rel_vec[g]) valid_q[g] <= 1'b0;
        end

        // Slot payload: captured on allocation, held otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[g]  <= '0;
                dst_q[g]  <= '0;
                prio_q[g] <= '0;
                port_q[g] <= '0;
                np_q[g]   <= 1'b0;
            end else if (load) begin
                src_q[g]  <= wr_src;
                dst_q[g]  <= wr_dst;
                prio_q[g] <= wr_prio;
                port_q[g] <= wr_port;
                np_q[g]   <= wr_np;
            end
        end
    end

endmodule

// File: rtl/ios_order_stall.sv
// Module: inbound request ordering stall unit (top).
// Accepts requests in order, issues them to DMA in the same cycle with a
// table tag, holds a request while an in-flight entry of the same source,
// destination and no lower priority exists or the table is full, and emits
// a swapped-ID response header on the ingress port when a non-posted entry
// completes. Assumes the DMA side always takes an issued request.
module ios_order_stall
    import ios_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int PRIO_W = 2,
    parameter int PORT_W = 2,
    parameter int DEPTH  = 8,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_src,
    input  logic [ID_W-1:0]   req_dst,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [PORT_W-1:0] req_port,
    input  logic [1:0]        req_kind,
    output logic              iss_valid,
    output logic [TAG_W-1:0]  iss_tag,
    output logic [ID_W-1:0]   iss_src,
    output logic [ID_W-1:0]   iss_dst,
    output logic [PRIO_W-1:0] iss_prio,
    output logic [1:0]        iss_kind,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    output logic              rsp_valid,
    output logic [PORT_W-1:0] rsp_port,
    output logic [ID_W-1:0]   rsp_src,
    output logic [ID_W-1:0]   rsp_dst,
    output logic [PRIO_W-1:0] rsp_prio
);

    logic [DEPTH-1:0]             valid_q;
    logic [DEPTH-1:0][ID_W-1:0]   src_q;
    logic [DEPTH-1:0][ID_W-1:0]   dst_q;
    logic [DEPTH-1:0][PRIO_W-1:0] prio_q;
    logic [DEPTH-1:0][PORT_W-1:0] port_q;
    logic [DEPTH-1:0]             np_q;

    logic             freeing;
    logic [DEPTH-1:0] rel_vec;
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] hit_vec;
    logic [TAG_W-1:0] alloc_idx;
    logic             any_free;
    logic             stall;
    logic             accept;

    // Completion qualification: only a tag naming a pending slot frees it.
    always_comb begin
        freeing = cpl_valid && valid_q[cpl_tag];
        rel_vec = '0;
        if (freeing) rel_vec[cpl_tag] = 1'b1;
        live = valid_q & ~rel_vec;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        ios_entry_match #(
            .ID_W   (ID_W),
            .PRIO_W (PRIO_W)
        ) u_match (
            .live     (live[g]),
            .ent_src  (src_q[g]),
            .ent_dst  (dst_q[g]),
            .ent_prio (prio_q[g]),
            .new_src  (req_src),
            .new_dst  (req_dst),
            .new_prio (req_prio),
            .hit      (hit_vec[g])
        );
    end

    ios_free_pick #(
        .DEPTH (DEPTH)
    ) u_pick (
        .free_vec (~live),
        .pick     (alloc_idx),
        .any_free (any_free)
    );

    // Stall decision and same-cycle pass-through to the DMA side.
    always_comb begin
        stall     = (|hit_vec) || !any_free;
        req_ready = !stall;
        accept    = req_valid && !stall;
        iss_valid = accept;
        iss_tag   = alloc_idx;
        iss_src   = req_src;
        iss_dst   = req_dst;
        iss_prio  = req_prio;
        iss_kind  = req_kind;
    end

    ios_pend_table #(
        .DEPTH  (DEPTH),
        .ID_W   (ID_W),
        .PRIO_W (PRIO_W),
        .PORT_W (PORT_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_idx  (alloc_idx),
        .wr_src  (req_src),
        .wr_dst  (req_dst),
        .wr_prio (req_prio),
        .wr_port (req_port),
        .wr_np   (needs_response(req_kind)),
        .rel_vec (rel_vec),
        .valid_q (valid_q),
        .src_q   (src_q),
        .dst_q   (dst_q),
        .prio_q  (prio_q),
        .port_q  (port_q),
        .np_q    (np_q)
    );

    // Response header register: swapped IDs, original port, one cycle after completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_port  <= '0;
            rsp_src   <= '0;
            rsp_dst   <= '0;
            rsp_prio  <= '0;
        end else begin
            rsp_valid <= freeing && np_q[cpl_tag];
            rsp_port  <= port_q[cpl_tag];
            rsp_src   <= dst_q[cpl_tag];
            rsp_dst   <= src_q[cpl_tag];
            rsp_prio  <= prio_q[cpl_tag];
        end
    end

endmodule

// File: rtl/ios_order_stall_chk.sv
// Module: assertion checker for ios_order_stall, bound to every instance.
// Keeps its own occupancy map built from the issue and completion ports.
module ios_order_stall_chk #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             iss_valid,
    input logic [TAG_W-1:0] iss_tag,
    input logic             cpl_valid,
    input logic [TAG_W-1:0] cpl_tag,
    input logic             rsp_valid
);

    logic [DEPTH-1:0] occ;
    logic             cpl_hits;

    assign cpl_hits = cpl_valid && occ[cpl_tag];

    // Port-side occupancy: issue sets a slot, completion clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cpl_valid && cpl_tag == TAG_W'(i)) occ[i] <= 1'b0;
                if (iss_valid && iss_tag == TAG_W'(i)) occ[i] <= 1'b1;
            end
        end
    end

    // R1: table starts empty, so the first cycle after reset is ready.
    a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> req_ready);

    // R2: an accepted request is issued in the same cycle.
    a_r2_same_cycle_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> iss_valid);

    // R8: an issued tag never names a slot still occupied.
    a_r8_tag_free: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (!occ[iss_tag] || (cpl_valid && cpl_tag == iss_tag)));

    // R7: a full table without a releasing completion is not ready.
    a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ((&occ) && !cpl_hits) |-> !req_ready);

    // R10: a stray completion produces no response.
    a_r10_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !occ[cpl_tag]) |=> !rsp_valid);

    // R9: a response always follows a completion of a pending slot.
    a_r9_rsp_from_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cpl_hits));

endmodule

bind ios_order_stall ios_order_stall_chk #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .iss_valid (iss_valid),
    .iss_tag   (iss_tag),
    .cpl_valid (cpl_valid),
    .cpl_tag   (cpl_tag),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_ios_order_stall.sv
// Bench: directed corner cases then seeded random traffic, checked against
// a reference table model kept in the bench.
module tb_ios_order_stall;

    localparam int ID_W = 8, PRIO_W = 2, PORT_W = 2, DEPTH = 8, TAG_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ID_W-1:0]   req_src = '0, req_dst = '0;
    logic [PRIO_W-1:0] req_prio = '0;
    logic [PORT_W-1:0] req_port = '0;
    logic [1:0]        req_kind = '0;
    logic              iss_valid;
    logic [TAG_W-1:0]  iss_tag;
    logic [ID_W-1:0]   iss_src, iss_dst;
    logic [PRIO_W-1:0] iss_prio;
    logic [1:0]        iss_kind;
    logic              cpl_valid = 1'b0;
    logic [TAG_W-1:0]  cpl_tag = '0;
    logic              rsp_valid;
    logic [PORT_W-1:0] rsp_port;
    logic [ID_W-1:0]   rsp_src, rsp_dst;
    logic [PRIO_W-1:0] rsp_prio;

    always #4 clk = ~clk;   // 125 MHz

    ios_order_stall dut (.*);

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Reference model state
    bit                mv[DEPTH];
    logic [ID_W-1:0]   ms[DEPTH], md[DEPTH];
    logic [PRIO_W-1:0] mp[DEPTH];
    logic [PORT_W-1:0] mport[DEPTH];
    bit                mnp[DEPTH];
    bit                erv = 0, stray_prev = 0;
    logic [PORT_W-1:0] erport;
    logic [ID_W-1:0]   ers, erd;
    logic [PRIO_W-1:0] erp;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit is_np(input logic [1:0] k);
        return k < 2;
    endfunction

    // One clock cycle: drive, check outputs against the model, advance the model.
    task automatic step(input bit rv, input logic [ID_W-1:0] s, input logic [ID_W-1:0] d,
                        input logic [1:0] p, input logic [1:0] pt, input logic [1:0] k,
                        input bit cv, input logic [2:0] ct);
        bit eff[DEPTH];
        bit freeing, match, match_posted, full, exp_rdy, helped;
        int alloc;
        @(negedge clk);
        req_valid = rv; req_src = s; req_dst = d; req_prio = p; req_port = pt; req_kind = k;
        cpl_valid = cv; cpl_tag = ct;
        #1;
        // Registered response from the previous cycle's completion
        chk(rsp_valid == erv, stray_prev ? "R10 stray completion" : "R9 rsp_valid",
            int'(rsp_valid), int'(erv));
        if (erv) begin
            chk(rsp_port == erport, "R9 rsp_port", int'(rsp_port), int'(erport));
            chk(rsp_src == ers, "R9 rsp_src swapped", int'(rsp_src), int'(ers));
            chk(rsp_dst == erd, "R9 rsp_dst swapped", int'(rsp_dst), int'(erd));
            chk(rsp_prio == erp, "R9 rsp_prio", int'(rsp_prio), int'(erp));
        end
        freeing = cv && mv[ct];
        match = 0; match_posted = 0; full = 1; alloc = -1; helped = 0;
        for (int i = 0; i < DEPTH; i++) begin
            eff[i] = mv[i] && !(freeing && ct == 3'(i));
            if (eff[i] && ms[i] == s && md[i] == d && mp[i] >= p) begin
                match = 1;
                if (!mnp[i]) match_posted = 1;
            end
            if (freeing && ct == 3'(i) && ((ms[i] == s && md[i] == d && mp[i] >= p) || full))
                helped = 1;
            if (!eff[i]) begin
                full = 0;
                if (alloc < 0) alloc = i;
            end
        end
        if (freeing && alloc == int'(ct)) helped = 1;
        exp_rdy = !match && !full;
        if (rv) begin
            string lbl;
            if (!exp_rdy) lbl = full ? "R7 full table" : (match_posted ? "R6 posted match" : "R3 match stall");
            else lbl = helped ? "R5 same-cycle release" : "R4 no conflict";
            chk(req_ready == exp_rdy, lbl, int'(req_ready), int'(exp_rdy));
        end
        chk(iss_valid == (rv && exp_rdy), "R2 iss_valid", int'(iss_valid), int'(rv && exp_rdy));
        if (rv && exp_rdy) begin
            chk(iss_tag == 3'(alloc), "R8 lowest free tag", int'(iss_tag), alloc);
            chk(iss_src == s && iss_dst == d && iss_prio == p && iss_kind == k,
                "R2 issue fields", int'({iss_src, iss_dst}), int'({s, d}));
        end
        // Advance model
        stray_prev = cv && !mv[ct];
        erv = freeing && mnp[ct];
        if (freeing) begin
            erport = mport[ct]; ers = md[ct]; erd = ms[ct]; erp = mp[ct];
            mv[ct] = 0;
        end
        if (rv && exp_rdy) begin
            mv[alloc] = 1; ms[alloc] = s; md[alloc] = d; mp[alloc] = p;
            mport[alloc] = pt; mnp[alloc] = is_np(k);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) mv[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

        // Directed: basic pass, priority boundary, release, response
        step(1, 8'd1, 8'd2, 2'd1, 2'd2, 2'd0, 0, 0);   // tag 0, read on port 2
        step(1, 8'd1, 8'd2, 2'd1, 2'd0, 2'd0, 0, 0);   // equal prio -> stall
        step(1, 8'd1, 8'd2, 2'd0, 2'd0, 2'd0, 0, 0);   // lower prio -> stall
        step(1, 8'd1, 8'd2, 2'd2, 2'd1, 2'd1, 0, 0);   // higher prio -> pass, tag 1
        step(1, 8'd1, 8'd3, 2'd0, 2'd1, 2'd0, 0, 0);   // other dst -> pass, tag 2
        step(0, 8'd0, 8'd0, 2'd0, 2'd0, 2'd0, 1, 3'd5); // stray completion
        step(1, 8'd1, 8'd2, 2'd1, 2'd0, 2'd0, 1, 3'd0); // tag1 still matches -> stall
        step(1, 8'd1, 8'd2, 2'd1, 2'd0, 2'd0, 1, 3'd1); // last match freed -> pass
        // Posted writes tracked
        step(1, 8'd7, 8'd7, 2'd3, 2'd3, 2'd2, 0, 0);
        step(1, 8'd7, 8'd7, 2'd3, 2'd3, 2'd3, 0, 0);   // stall on posted entry
        step(0, 8'd0, 8'd0, 2'd0, 2'd0, 2'd0, 1, 3'd1); // posted completes: no rsp
        // Fill the table
        for (int i = 0; i < 6; i++) step(1, 8'(20 + i), 8'd9, 2'd0, 2'd1, 2'd1, 0, 0);
        step(1, 8'd50, 8'd50, 2'd0, 2'd0, 2'd0, 0, 0); // full -> stall
        step(1, 8'd50, 8'd50, 2'd0, 2'd0, 2'd0, 1, 3'd4); // full + completion -> pass
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 0, 0, 1, 3'(i));

        // Random traffic over a small ID space to force conflicts
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 10) < 7, 8'($urandom % 2), 8'($urandom % 2),
                 2'($urandom), 2'($urandom), 2'($urandom),
                 ($urandom % 10) < 4, 3'($urandom));
        end
        step(0, 0, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule